// File: doc/BRIEF.md
# Multiphase Control-Point Phase Decoder

During logic self-test, some faults are hard to reach with pseudorandom patterns alone. Control points help with this. This block counts the patterns applied in a self-test run and splits the run into `NGROUPS + 1` phases of equal length. The default is four groups, so the run has five phases, numbered 0 to 4.

Each phase is decoded into one enable line per control-point group. Phase 0 targets no group. In each later phase exactly one group is targeted, so every group is exercised in a window of its own. The enables are quasi-static: they stay fixed for a whole phase and change only when the pattern counter crosses a phase boundary. Because all control points are driven from one decoder, their values are strongly correlated with each other.

The self-test sequencer pulses `pat_adv` once for each applied pattern. The block also holds one AND-type control-point cell and one OR-type control-point cell per group. These show how the decoded enables act on a logic node. When `test_mode` is low, every cell is transparent and the phase state is held cleared.

Top module: `mtp_phase_top`

## Requirements
- R1: While `rst_n` is low, `phase` is 0, `phase_done` is 0 and every `grp_n` line is 0.
- R2: In phase 0 every `grp_n` line is 0, no group is selected, and `and_out` equals `and_in` and `or_out` equals `or_in`.
- R3: In phase k (1..NGROUPS), `grp_n` bit k-1 is 0 and every other bit is 1, so bit 0 belongs to the first group.
- R4: The phase rises by exactly one on the strobe that completes `PATS_PER_PHASE` strobes within the current phase. It never changes on any other cycle.
- R5: Only cycles with `pat_adv` high count as patterns. Idle cycles leave the phase and the in-phase count unchanged.
- R6: After `PATS_PER_PHASE` strobes in phase NGROUPS, `phase_done` rises and `phase` stays at NGROUPS. Further strobes have no effect.
- R7: An AND-type cell drives its output to 0 while `test_mode` is high and its group is selected. Otherwise the output equals its input.
- R8: An OR-type cell drives its output to 1 while `test_mode` is high and its group is selected. Otherwise the output equals its input.
- R9: When `test_mode` is low, the cells are transparent in the same cycle. From the next clock edge `phase` is 0 and `phase_done` is 0, and strobes are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| test_mode | input | 1 | Self-test mode; low clears phase state and makes the cells transparent |
| pat_adv | input | 1 | One-cycle strobe per applied pattern |
| and_in | input | NGROUPS (4) | Nodes feeding the AND-type cells, one per group |
| or_in | input | NGROUPS (4) | Nodes feeding the OR-type cells, one per group |
| phase | output | PHW (3) | Current phase index |
| grp_n | output | NGROUPS (4) | Decoded group enable lines, active low |
| phase_done | output | 1 | Last phase completed |
| and_out | output | NGROUPS (4) | AND-type cell outputs |
| or_out | output | NGROUPS (4) | OR-type cell outputs |

## Verification
`phase` and `phase_done` come from registers. A strobe that is high across a rising edge shows its effect on those registers right after that edge. `grp_n` and the two cell outputs follow the registered phase combinationally, so they change in the same cycle as `phase`. The cell outputs also react at once to `test_mode`, `and_in` and `or_in`, with no clock needed.

The bench drives inputs at falling edges and reads outputs one nanosecond after a later falling edge. Every register result is therefore read half a cycle after the edge that produced it. The combinational cell checks are read after a short settle time with no clock in between.

// File: rtl/mtp_pkg.sv
package mtp_pkg;

  typedef enum logic {
    CP_FORCE0 = 1'b0,
    CP_FORCE1 = 1'b1
  } cp_kind_e;

  // Applies a control point: passes the node through unless forced.
  function automatic logic cp_apply(cp_kind_e kind, logic node, logic force_en);
    if (!force_en) return node;
    return (kind == CP_FORCE1);
  endfunction

  // Enable line level for one group given phase equality and phase zero.
  function automatic logic line_level(logic is_phase_zero, logic is_my_phase);
    if (is_phase_zero) return 1'b0;
    return !is_my_phase;
  endfunction

endpackage

// File: rtl/mtp_pattern_counter.sv
module mtp_pattern_counter #(
  parameter int NGROUPS        = 4,
  parameter int PATS_PER_PHASE = 8,
  localparam int PHW  = $clog2(NGROUPS + 1),
  localparam int CNTW = (PATS_PER_PHASE > 1) ? $clog2(PATS_PER_PHASE) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           test_mode,
  input  logic           pat_adv,
  output logic [PHW-1:0] phase,
  output logic           phase_done
);

  localparam logic [CNTW-1:0] LAST_CNT   = CNTW'(PATS_PER_PHASE - 1);
  localparam logic [PHW-1:0]  LAST_PHASE = PHW'(NGROUPS);

  logic [CNTW-1:0] in_cnt;
  logic            count_ev;
  logic            boundary_ev;
  logic            finish_ev;

  assign count_ev    = test_mode && pat_adv && !phase_done;
  assign boundary_ev = count_ev && (in_cnt == LAST_CNT) && (phase != LAST_PHASE);
  assign finish_ev   = count_ev && (in_cnt == LAST_CNT) && (phase == LAST_PHASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_cnt     <= '0;
      phase      <= '0;
      phase_done <= 1'b0;
    end else if (!test_mode) begin
      in_cnt     <= '0;
      phase      <= '0;
      phase_done <= 1'b0;
    end else if (count_ev) begin
      if (in_cnt == LAST_CNT) begin
        in_cnt <= '0;
        if (finish_ev) phase_done <= 1'b1;
        else           phase      <= phase + 1'b1;
      end else begin
        in_cnt <= in_cnt + 1'b1;
      end
    end
  end

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= LAST_PHASE); // R4
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    boundary_ev |=> (phase == $past(phase) + 1'b1)); // R4
  AST_PHASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && !boundary_ev) |=> $stable(phase)); // R5
  AST_DONE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    phase_done |-> (phase == LAST_PHASE)); // R6
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_done && test_mode) |=> phase_done); // R6
  AST_TM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |=> (phase == '0 && !phase_done)); // R9

endmodule

// File: rtl/mtp_phase_decoder.sv
module mtp_phase_decoder
  import mtp_pkg::*;
#(
  parameter int NGROUPS = 4,
  localparam int PHW = $clog2(NGROUPS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PHW-1:0]     phase,
  output logic [NGROUPS-1:0] grp_n,
  output logic [NGROUPS-1:0] grp_sel
);

  logic phase_zero;
  assign phase_zero = (phase == '0);

  for (genvar g = 0; g < NGROUPS; g++) begin : g_line
    logic mine;
    assign mine       = (phase == PHW'(g + 1));
    assign grp_n[g]   = line_level(phase_zero, mine);
    assign grp_sel[g] = mine;
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grp_sel)); // R3
  AST_ZERO_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == '0) |-> (grp_n == '0 && grp_sel == '0)); // R2
  AST_ONE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != '0) |-> ($countones(grp_n) == NGROUPS - 1)); // R3

endmodule

// File: rtl/mtp_ctrl_point.sv
module mtp_ctrl_point
  import mtp_pkg::*;
#(
  parameter cp_kind_e KIND = CP_FORCE0
) (
  input  logic test_mode,
  input  logic sel,
  input  logic node_in,
  output logic node_out
);

  logic force_en;
  assign force_en = test_mode && sel;
  assign node_out = cp_apply(KIND, node_in, force_en);

endmodule

// File: rtl/mtp_phase_top.sv
module mtp_phase_top
  import mtp_pkg::*;
#(
  parameter int NGROUPS        = 4,
  parameter int PATS_PER_PHASE = 8,
  localparam int PHW = $clog2(NGROUPS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               test_mode,
  input  logic               pat_adv,
  input  logic [NGROUPS-1:0] and_in,
  input  logic [NGROUPS-1:0] or_in,
  output logic [PHW-1:0]     phase,
  output logic [NGROUPS-1:0] grp_n,
  output logic               phase_done,
  output logic [NGROUPS-1:0] and_out,
  output logic [NGROUPS-1:0] or_out
);

  logic [NGROUPS-1:0] grp_sel;

  mtp_pattern_counter #(
    .NGROUPS(NGROUPS), .PATS_PER_PHASE(PATS_PER_PHASE)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .pat_adv(pat_adv),
    .phase(phase), .phase_done(phase_done)
  );

  mtp_phase_decoder #(.NGROUPS(NGROUPS)) u_dec (
    .clk(clk), .rst_n(rst_n), .phase(phase), .grp_n(grp_n), .grp_sel(grp_sel)
  );

  for (genvar g = 0; g < NGROUPS; g++) begin : g_cp
    mtp_ctrl_point #(.KIND(CP_FORCE0)) u_and (
      .test_mode(test_mode), .sel(grp_sel[g]), .node_in(and_in[g]), .node_out(and_out[g])
    );
    mtp_ctrl_point #(.KIND(CP_FORCE1)) u_or (
      .test_mode(test_mode), .sel(grp_sel[g]), .node_in(or_in[g]), .node_out(or_out[g])
    );
  end

  AST_AND_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && phase != '0) |-> !and_out[phase - 1'b1]); // R7
  AST_OR_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    (test_mode && phase != '0) |-> or_out[phase - 1'b1]); // R8
  AST_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_mode || phase == '0) |-> (and_out == and_in && or_out == or_in)); // R2 R9

endmodule

// File: tb/test_mtp_phase_top.sv
`timescale 1ns/1ps
module test_mtp_phase_top;
  localparam int NG  = 4;
  localparam int PPP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic test_mode = 1'b0;
  logic pat_adv = 1'b0;
  logic [NG-1:0] and_in = '1;
  logic [NG-1:0] or_in = '0;
  logic [2:0] phase;
  logic [NG-1:0] grp_n;
  logic phase_done;
  logic [NG-1:0] and_out;
  logic [NG-1:0] or_out;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  mtp_phase_top #(.NGROUPS(NG), .PATS_PER_PHASE(PPP)) i_mtp_phase_top (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .pat_adv(pat_adv),
    .and_in(and_in), .or_in(or_in), .phase(phase), .grp_n(grp_n),
    .phase_done(phase_done), .and_out(and_out), .or_out(or_out)
  );

  function automatic logic [NG-1:0] exp_lines(int p);
    logic [NG-1:0] v;
    if (p == 0) return '0;
    v = '1;
    v[p-1] = 1'b0;
    return v;
  endfunction

  function automatic logic [NG-1:0] exp_sel(int p, logic tm);
    logic [NG-1:0] v;
    v = '0;
    if (tm && p != 0) v[p-1] = 1'b1;
    return v;
  endfunction

  task automatic check(logic ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic strobe();
    @(negedge clk);
    pat_adv = 1'b1;
    @(negedge clk);
    pat_adv = 1'b0;
    #1;
  endtask

  task automatic check_state(int p, logic d, string req);
    logic [NG-1:0] s;
    s = exp_sel(p, test_mode);
    check(phase == 3'(p), req, "phase", phase, p);
    check(phase_done == d, req, "done", phase_done, d);
    check(grp_n == exp_lines(p), req, "grp_n", grp_n, exp_lines(p));
    check(and_out == (and_in & ~s), "R7", "and_out", and_out, and_in & ~s);
    check(or_out == (or_in | s), "R8", "or_out", or_out, or_in | s);
  endtask

  task automatic t_reset();
    test_mode = 1'b1;
    rst_n = 1'b0;
    settle();
    check_state(0, 1'b0, "R1");
    check(and_out == and_in && or_out == or_in, "R2", "transparent", and_out, and_in);
    rst_n = 1'b1;
    settle();
  endtask

  task automatic t_sweep();
    for (int n = 1; n <= PPP * (NG + 1); n++) begin
      int p;
      strobe();
      p = (n / PPP > NG) ? NG : n / PPP;
      if (n == PPP * (NG + 1)) check_state(NG, 1'b1, "R6");
      else if (p == 0) check_state(0, 1'b0, "R2");
      else check_state(p, 1'b0, (n % PPP == 0) ? "R4" : "R3");
    end
  endtask

  task automatic t_after_done();
    for (int i = 0; i < 3; i++) strobe();
    check_state(NG, 1'b1, "R6");
  endtask

  task automatic t_tm_off();
    and_in = 4'hA;
    or_in = 4'h5;
    test_mode = 1'b0;
    #1;
    check(and_out == and_in, "R9", "and_out comb", and_out, and_in);
    check(or_out == or_in, "R9", "or_out comb", or_out, or_in);
    settle();
    check_state(0, 1'b0, "R9");
    for (int i = 0; i < PPP + 2; i++) strobe();
    check_state(0, 1'b0, "R9");
    test_mode = 1'b1;
    and_in = '1;
    or_in = '0;
    settle();
  endtask

  task automatic t_gaps();
    for (int i = 0; i < PPP - 1; i++) strobe();
    for (int i = 0; i < 5; i++) settle();
    check_state(0, 1'b0, "R5");
    strobe();
    check_state(1, 1'b0, "R5");
    for (int i = 0; i < 4; i++) settle();
    check_state(1, 1'b0, "R5");
    and_in = 4'h3;
    or_in = 4'hC;
    #1;
    check_state(1, 1'b0, "R7");
  endtask

  initial begin
    t_reset();
    t_sweep();
    t_after_done();
    t_tm_off();
    t_gaps();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule